// File: doc/BRIEF.md
# Keyed Windowed Watchdog

This block is a watchdog counter that runs from its own slow clock and asks the system to reset when software stops servicing it. It also asks for a reset when software services it in the wrong way. Software services the counter by writing one byte through a bus-clock write port. The port also carries a flag that marks single-bit manipulation accesses. Only a full-byte write of the key value 0xAC counts as a refresh. After the first refresh since reset, a refresh is accepted only when the counter sits in the late, open part of its period.

Three static configuration inputs are captured while reset is held: an enable, a period select and a window select. The bus write is carried into the watchdog clock domain by a toggle handshake. The only output is a one-cycle reset request. After raising it, the block restarts as it would after reset.

Top module: `keyed_watchdog`

## Requirements
- R1: While reset is held and right after it is released, `rstReq` is low. The configuration inputs are captured on watchdog clock edges during reset and are held afterwards.
- R2: With `cfgEnable` = 0 the counter does not run and `rstReq` never rises. Writes of any kind have no effect.
- R3: With the block enabled and no writes, `rstReq` rises for the first time on watchdog edge P after reset release, where P = 2^(BASE_EXP + `cfgPeriodSel`). It then rises again every P edges.
- R4: An accepted refresh clears the counter on the third watchdog edge after the bus edge that captures the write. The next overflow request comes P edges after that clear.
- R5: A write whose data is not 0xAC raises `rstReq` on the edge where it is evaluated, whether the window is open or closed.
- R6: A write with `wrBitOp` = 1 raises `rstReq` on the edge where it is evaluated, even when the data is 0xAC.
- R7: The first 0xAC full-byte write after reset release, or after a reset request, is accepted at any count, whatever the window setting.
- R8: Every later refresh is accepted only when the count is at least S. S is P/2 for `cfgWindowSel` = 00, P/4 for 01, and 0 for 10 or 11. A refresh with the count below S raises `rstReq`.
- R9: A valid refresh that is evaluated while the count is P-1 clears the counter and suppresses the overflow request of that edge.
- R10: `rstReq` is high for exactly one watchdog cycle. The count then restarts from zero and the first-refresh state is cleared. A write evaluated in the cycle while `rstReq` is high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock of the write port |
| wdtClk | input | 1 | Watchdog counting clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| cfgEnable | input | 1 | 1: the counter runs after reset; 0: it stays stopped |
| cfgPeriodSel | input | 3 | Overflow period select n, period 2^(BASE_EXP+n) |
| cfgWindowSel | input | 2 | Open-window size: 00 half, 01 three quarters, 1x whole period |
| wrEn | input | 1 | One bus-clock strobe for a write to the refresh register |
| wrData | input | 8 | Data byte of the write |
| wrBitOp | input | 1 | Marks the write as a single-bit manipulation access |
| rstReq | output | 1 | One-cycle reset request in the watchdog domain |

## Verification
The bench places second refreshes exactly one count below and exactly at the window start for both partial window sizes. A design with an off-by-one compare would either reset on a legal refresh or accept an early one. It lands a refresh on the overflow count itself, where an overflow-first priority would reset a healthy system. It also lands a write in the cycle of a pulse, where a design that does not discard it would give a double pulse or a skewed restart. It sweeps all eight periods for exact overflow spacing, and it checks that a pulse clears the first-refresh state: a design that keeps that state would turn a legal early first refresh into a reset.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam logic [7:0] REFRESH_KEY = 8'hAC;

  typedef struct packed {
    logic       enable;
    logic [2:0] periodSel;
    logic [1:0] windowSel;
  } wdtCfg_t;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic run;
    logic clear;
  } cntStrobe_t;

endpackage

// File: rtl/kwdt_wr_sync.sv
module kwdt_wr_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       busClk,
  input  logic       wdtClk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       wrBitOp,
  output logic       evt,
  output logic [7:0] evtData,
  output logic       evtBit
);

  logic       reqTgl;
  logic [7:0] heldData;
  logic       heldBit;
  logic [SYNC_STAGES:0] syncChain;

  // bus side: capture the write and flip the request toggle
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      reqTgl   <= 1'b0;
      heldData <= '0;
      heldBit  <= 1'b0;
    end else if (wrEn) begin
      reqTgl   <= ~reqTgl;
      heldData <= wrData;
      heldBit  <= wrBitOp;
    end
  end

  // watchdog side: synchroniser stages plus one edge-detect stage
  always_ff @(posedge wdtClk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-1:0], reqTgl};
  end

  assign evt     = syncChain[SYNC_STAGES] ^ syncChain[SYNC_STAGES-1];
  assign evtData = heldData;  // stable for several edges before evt rises
  assign evtBit  = heldBit;

endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
(
  input  logic       wdtClk,
  input  logic       rstN,
  input  wdtCfg_t    cfgIn,
  input  logic       evt,
  input  logic [7:0] evtData,
  input  logic       evtBit,
  input  logic       atLast,
  input  logic       windowOpen,
  output wdtCfg_t    cfgQ,
  output cntStrobe_t strobe,
  output logic       rstReq
);

  logic frozen;
  logic refreshSeen;
  logic evtValid, keyOk, accept, violate, overflow, fire;

  // frozen stays low through reset, so cfgQ follows the pins until release
  always_ff @(posedge wdtClk or negedge rstN) begin
    if (!rstN) frozen <= 1'b0;
    else       frozen <= 1'b1;
  end

  always_ff @(posedge wdtClk) begin
    if (!frozen) cfgQ <= cfgIn;
  end

  always_comb begin
    evtValid = cfgQ.enable && evt && !rstReq;
    keyOk    = !evtBit && (evtData == REFRESH_KEY);
    accept   = evtValid && keyOk && (!refreshSeen || windowOpen);
    violate  = evtValid && !accept;
    overflow = cfgQ.enable && atLast && !accept && !rstReq;
    fire     = violate || overflow;
    strobe.run   = cfgQ.enable;
    strobe.clear = accept || fire;
  end

  always_ff @(posedge wdtClk or negedge rstN) begin
    if (!rstN) begin
      refreshSeen <= 1'b0;
      rstReq      <= 1'b0;
    end else begin
      rstReq <= fire;
      if (fire)        refreshSeen <= 1'b0;
      else if (accept) refreshSeen <= 1'b1;
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge wdtClk) disable iff (!rstN)
    rstReq |=> !rstReq);  // R10
  AST_STOPPED_QUIET: assert property (@(posedge wdtClk) disable iff (!rstN)
    !cfgQ.enable |=> !rstReq);  // R2
  AST_OVF_FIRES: assert property (@(posedge wdtClk) disable iff (!rstN)
    (cfgQ.enable && atLast && !evt) |=> rstReq);  // R3
  AST_BITOP_FIRES: assert property (@(posedge wdtClk) disable iff (!rstN)
    (cfgQ.enable && evt && evtBit && !rstReq) |=> rstReq);  // R6
  AST_BADKEY_FIRES: assert property (@(posedge wdtClk) disable iff (!rstN)
    (cfgQ.enable && evt && (evtData != REFRESH_KEY) && !rstReq) |=> rstReq);  // R5
  AST_FIRST_TAKEN: assert property (@(posedge wdtClk) disable iff (!rstN)
    (cfgQ.enable && evt && !evtBit && (evtData == REFRESH_KEY) && !refreshSeen && !rstReq)
      |=> (!rstReq && refreshSeen));  // R7

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int BASE_EXP = 7,
  localparam int CNT_W   = BASE_EXP + 7
) (
  input  logic       wdtClk,
  input  logic       rstN,
  input  cntStrobe_t strobe,
  input  logic [2:0] periodSel,
  input  logic [1:0] windowSel,
  output logic       atLast,
  output logic       windowOpen
);

  logic [CNT_W-1:0] count;
  logic [CNT_W:0]   periodVal;
  logic [CNT_W:0]   lastVal;
  logic [CNT_W:0]   openStart;

  always_comb begin
    periodVal = (CNT_W+1)'(1) << (BASE_EXP + int'(periodSel));
    lastVal   = periodVal - (CNT_W+1)'(1);
    unique case (windowSel)
      2'b00:   openStart = periodVal >> 1;
      2'b01:   openStart = periodVal >> 2;
      default: openStart = '0;
    endcase
    atLast     = ({1'b0, count} == lastVal);
    windowOpen = ({1'b0, count} >= openStart);
  end

  always_ff @(posedge wdtClk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (strobe.clear) count <= '0;
    else if (strobe.run)   count <= count + CNT_W'(1);
  end

  AST_COUNT_BOUND: assert property (@(posedge wdtClk) disable iff (!rstN)
    ({1'b0, count} < periodVal));  // R3
  AST_CLEAR_ZERO: assert property (@(posedge wdtClk) disable iff (!rstN)
    strobe.clear |=> (count == '0));  // R4
  AST_IDLE_HOLD: assert property (@(posedge wdtClk) disable iff (!rstN)
    (!strobe.run && !strobe.clear) |=> $stable(count));  // R2

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwdt_pkg::*;
#(
  parameter int BASE_EXP    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic       busClk,
  input  logic       wdtClk,
  input  logic       rstN,
  input  logic       cfgEnable,
  input  logic [2:0] cfgPeriodSel,
  input  logic [1:0] cfgWindowSel,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       wrBitOp,
  output logic       rstReq
);

  wdtCfg_t    cfgIn, cfgQ;
  cntStrobe_t strobe;
  logic       evt, evtBit, atLast, windowOpen;
  logic [7:0] evtData;

  assign cfgIn = '{enable: cfgEnable, periodSel: cfgPeriodSel, windowSel: cfgWindowSel};

  kwdt_wr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .busClk(busClk), .wdtClk(wdtClk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData), .wrBitOp(wrBitOp),
    .evt(evt), .evtData(evtData), .evtBit(evtBit)
  );

  kwdt_ctrl u_ctrl (
    .wdtClk(wdtClk), .rstN(rstN), .cfgIn(cfgIn),
    .evt(evt), .evtData(evtData), .evtBit(evtBit),
    .atLast(atLast), .windowOpen(windowOpen),
    .cfgQ(cfgQ), .strobe(strobe), .rstReq(rstReq)
  );

  kwdt_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
    .wdtClk(wdtClk), .rstN(rstN), .strobe(strobe),
    .periodSel(cfgQ.periodSel), .windowSel(cfgQ.windowSel),
    .atLast(atLast), .windowOpen(windowOpen)
  );

endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

  localparam int BASE_EXP = 4;

  logic busClk = 1'b0, wdtClk = 1'b0, rstN = 1'b0;
  logic cfgEnable = 1'b0, wrEn = 1'b0, wrBitOp = 1'b0;
  logic [2:0] cfgPeriodSel = '0;
  logic [1:0] cfgWindowSel = '0;
  logic [7:0] wrData = '0;
  logic rstReq;

  int nChk = 0, nFail = 0;
  int wdtTotal = 0, cyc0 = 0;
  int pulseTotal = 0, basePulse = 0, lastPulseAbs = 0, widthErr = 0;
  bit prevHigh = 1'b0;
  bit finished = 1'b0;

  always #5  busClk = ~busClk;
  always #20 wdtClk = ~wdtClk;

  keyed_watchdog #(.BASE_EXP(BASE_EXP)) u_dut (
    .busClk(busClk), .wdtClk(wdtClk), .rstN(rstN),
    .cfgEnable(cfgEnable), .cfgPeriodSel(cfgPeriodSel), .cfgWindowSel(cfgWindowSel),
    .wrEn(wrEn), .wrData(wrData), .wrBitOp(wrBitOp), .rstReq(rstReq)
  );

  always @(posedge wdtClk) wdtTotal++;

  always @(negedge wdtClk) begin
    if (rstReq) begin
      pulseTotal++;
      lastPulseAbs = wdtTotal;
      if (prevHigh) widthErr++;
    end
    prevHigh = rstReq;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applyReset(input logic en, input logic [2:0] sel, input logic [1:0] win);
    rstN = 1'b0;
    wrEn = 1'b0;
    cfgEnable = en;
    cfgPeriodSel = sel;
    cfgWindowSel = win;
    repeat (3) @(negedge wdtClk);
    rstN = 1'b1;
    cyc0 = wdtTotal;
    basePulse = pulseTotal;
  endtask

  task automatic waitTo(input int n);
    while (wdtTotal - cyc0 < n) @(negedge wdtClk);
  endtask

  // bus write launched right after the negedge ending relative cycle n
  task automatic wr(input int n, input logic [7:0] d, input logic b);
    waitTo(n);
    #2;
    wrEn = 1'b1; wrData = d; wrBitOp = b;
    @(posedge busClk);
    #2;
    wrEn = 1'b0; wrBitOp = 1'b0;
  endtask

  task automatic chkAt(input int n, input int expCnt, input int expLast, input string req);
    waitTo(n);
    #5;
    check(pulseTotal - basePulse == expCnt, req, pulseTotal - basePulse, expCnt);
    if (expLast >= 0)
      check(lastPulseAbs - cyc0 == expLast, req, lastPulseAbs - cyc0, expLast);
  endtask

  initial begin
    repeat (150000) @(posedge busClk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    // R1 and R3: sweep every period, two overflows each, R10 spacing
    for (int sel = 0; sel < 8; sel++) begin
      int p;
      p = 16 << sel;
      applyReset(1'b1, 3'(sel), 2'b00);
      #5;
      check(rstReq == 1'b0, "R1 reset state", int'(rstReq), 0);
      chkAt(p - 1, 0, -1, "R3 no early overflow");
      chkAt(p + 1, 1, p, "R3 first overflow");
      chkAt(2 * p + 1, 2, 2 * p, "R10 restart after pulse");
    end

    // R2: disabled watchdog ignores everything
    applyReset(1'b0, 3'd0, 2'b00);
    wr(2, 8'h55, 1'b0);
    wr(6, 8'hAC, 1'b1);
    wr(10, 8'hAC, 1'b0);
    chkAt(100, 0, -1, "R2 stopped");

    // R5: wrong key early
    applyReset(1'b1, 3'd1, 2'b00);
    wr(4, 8'hAD, 1'b0);
    chkAt(8, 1, 7, "R5 wrong key");

    // R6: bit access with key data
    applyReset(1'b1, 3'd1, 2'b00);
    wr(4, 8'hAC, 1'b1);
    chkAt(8, 1, 7, "R6 bit access");

    // R7 and R4: first refresh in closed window accepted, clear at edge 5
    applyReset(1'b1, 3'd1, 2'b00);
    wr(2, 8'hAC, 1'b0);
    chkAt(36, 0, -1, "R7 first refresh accepted");
    chkAt(38, 1, 37, "R4 overflow after clear");

    // R8: second refresh, half window, count 7 closed
    applyReset(1'b1, 3'd1, 2'b00);
    wr(2, 8'hAC, 1'b0);
    wr(10, 8'hAC, 1'b0);
    chkAt(14, 1, 13, "R8 closed window");

    // R8: boundary, count 15 closed
    applyReset(1'b1, 3'd1, 2'b00);
    wr(2, 8'hAC, 1'b0);
    wr(18, 8'hAC, 1'b0);
    chkAt(22, 1, 21, "R8 one below start");

    // R8: boundary, count 16 open
    applyReset(1'b1, 3'd1, 2'b00);
    wr(2, 8'hAC, 1'b0);
    wr(19, 8'hAC, 1'b0);
    chkAt(53, 0, -1, "R8 at start accepted");
    chkAt(55, 1, 54, "R8 at start overflow");

    // R8: three-quarter window, start 8
    applyReset(1'b1, 3'd1, 2'b01);
    wr(2, 8'hAC, 1'b0);
    wr(10, 8'hAC, 1'b0);
    chkAt(14, 1, 13, "R8 quarter closed");
    applyReset(1'b1, 3'd1, 2'b01);
    wr(2, 8'hAC, 1'b0);
    wr(11, 8'hAC, 1'b0);
    chkAt(45, 0, -1, "R8 quarter open");
    chkAt(47, 1, 46, "R8 quarter overflow");

    // R8: full window codes 10 and 11
    for (int w = 2; w < 4; w++) begin
      applyReset(1'b1, 3'd1, 2'(w));
      wr(2, 8'hAC, 1'b0);
      wr(5, 8'hAC, 1'b0);
      chkAt(39, 0, -1, "R8 full window");
      chkAt(41, 1, 40, "R8 full window overflow");
    end

    // R9: second refresh evaluated on count P-1
    applyReset(1'b1, 3'd1, 2'b00);
    wr(2, 8'hAC, 1'b0);
    wr(34, 8'hAC, 1'b0);
    chkAt(68, 0, -1, "R9 last-count refresh wins");
    chkAt(70, 1, 69, "R9 overflow after late clear");

    // R9: first refresh evaluated on count P-1
    applyReset(1'b1, 3'd1, 2'b00);
    wr(29, 8'hAC, 1'b0);
    chkAt(63, 0, -1, "R9 first on last count");
    chkAt(65, 1, 64, "R9 first overflow");

    // R10: write evaluated during pulse cycle is discarded
    applyReset(1'b1, 3'd1, 2'b00);
    wr(30, 8'hAC, 1'b0);
    chkAt(33, 1, 32, "R10 pulse");
    chkAt(63, 1, 32, "R10 discarded write");
    chkAt(65, 2, 64, "R10 count restart");

    // R10: first-refresh state cleared by pulse
    applyReset(1'b1, 3'd1, 2'b00);
    wr(2, 8'hAC, 1'b0);
    chkAt(38, 1, 37, "R10 overflow");
    wr(39, 8'hAC, 1'b0);
    chkAt(73, 1, 37, "R10 first refresh again");
    chkAt(75, 2, 74, "R10 overflow after refresh");

    // R5: wrong key in open window
    applyReset(1'b1, 3'd1, 2'b00);
    wr(2, 8'hAC, 1'b0);
    wr(25, 8'hCA, 1'b0);
    chkAt(29, 1, 28, "R5 wrong key open window");

    check(widthErr == 0, "R10 pulse width", widthErr, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule